// File: doc/BRIEF.md
# Serial Loopback Self-Test Checker

This block watches the wraparound path of a serial bus terminal while it is in service. Every 16-bit word that the encoder sends returns through the receiver. The decoder reports each returned word with a strobe and four error flags, one per validity check. The checker has two jobs. First, it records any validity error seen on any returned word of the current message. Second, it holds the most recently sent word and the most recently returned word, so that the final word of the message can be compared bit by bit.

A transmitter watchdog counts the clocks in which the transmitter is active since the message began. The limit it compares against is picked by a protocol revision input. One setting selects the limit of the older revision and the other selects the limit of the newer one.

At the end of each message the block makes one decision. It presents a loop-test-fail bit for the message's block status word, pulses a "result ready" strobe, and, if interrupts are enabled and the message failed, pulses an interrupt request for one clock.

Top module: `loopback_selftest`

## Requirements
- R1: After reset, `status_fail`, `status_done` and `irq` are all 0.
- R2: If any returned word between `msg_start` and `msg_end` arrives with one of its flags high (`rx_sync_err`, `rx_enc_err`, `rx_cnt_err` or `rx_par_err`), the message fails. A flag is high (1) for an error. The parity flag reports a violation of odd parity over the 16 data bits.
- R3: At `msg_end`, the last returned word is compared with the last sent word on all 16 bits, and any difference fails the message. A mismatch on an earlier word of the message has no effect on the result.
- R4: If no returned word arrives after the last `tx_strobe` of the message (or no word was sent at all), the message fails at `msg_end`. A missing echo of an earlier word has no effect on the result.
- R5: The number of clocks with `tx_active` high since `msg_start` is compared with a limit. If that number is at or above the limit, the message fails. With `rev_b`=0 the limit is LIM_A; with `rev_b`=1 it is LIM_B.
- R6: A message in which every returned word is clean, the last returned word equals the last sent word, and the watchdog limit is not reached, passes with `status_fail`=0.
- R7: `status_done` is high for exactly the one clock that follows the `msg_end` clock. `status_fail` takes the new result in that same clock and then holds it until the next message ends.
- R8: `irq` pulses for one clock together with `status_done`, and only if the message failed and `irq_en` was 1 at `msg_end`.
- R9: `msg_start` clears the recorded validity error, the echo state and the watchdog count, so no failure carries over into the next message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_start | input | 1 | One-clock strobe at the start of a message |
| msg_end | input | 1 | One-clock strobe that ends a message and triggers the decision |
| rev_b | input | 1 | Watchdog limit select: 0 selects LIM_A, 1 selects LIM_B |
| irq_en | input | 1 | Allows an interrupt pulse when a message fails |
| tx_active | input | 1 | Transmitter busy; counted by the watchdog |
| tx_strobe | input | 1 | Encoder has sent `tx_word` |
| tx_word | input | 16 | Word handed to the encoder |
| rx_valid | input | 1 | Decoder has returned `rx_word` |
| rx_word | input | 16 | Decoded returned word |
| rx_sync_err | input | 1 | Sync error on the returned word |
| rx_enc_err | input | 1 | Encoding error on the returned word |
| rx_cnt_err | input | 1 | Bit count error on the returned word |
| rx_par_err | input | 1 | Odd parity error on the returned word |
| status_fail | output | 1 | Loop-test-fail bit of the last finished message |
| status_done | output | 1 | One-clock strobe: result of a message is ready |
| irq | output | 1 | One-clock interrupt request for a failed message |

## Verification
The assertions assume well-formed input strobes: `msg_start` and `msg_end` never fall in the same clock or in two consecutive clocks, and `tx_strobe` and `rx_valid` never fall in the same clock. They also assume that `rev_b` does not change within a message. The bench drives each message as a fixed sequence. It raises `msg_start` for one clock, then gives each word a send clock followed by a separate echo clock, then adds the extra active clocks, and then sends a single `msg_end` followed by idle clocks. Every strobe is therefore isolated. Within that framework the word counts, data, corrupted positions, flag kinds and active lengths are drawn at random.

// File: rtl/lbt_pkg.sv
package lbt_pkg;
   typedef struct packed {
      logic flag_err;
      logic no_echo;
      logic mismatch;
      logic timeout;
   } fail_cause_t;

   localparam int FLAG_N = 4;
endpackage

// File: rtl/lbt_watchdog.sv
module lbt_watchdog #(
   parameter int LIM_A = 24,
   parameter int LIM_B = 48
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic active,
   input  logic rev_b,
   output logic expired
);
   localparam int LIM_MAX = (LIM_A > LIM_B) ? LIM_A : LIM_B;
   localparam int CW      = $clog2(LIM_MAX + 1);

   if (LIM_A < 1) begin : g_bad_lim_a
      $error("lbt_watchdog: LIM_A must be at least 1");
   end
   if (LIM_B < 1) begin : g_bad_lim_b
      $error("lbt_watchdog: LIM_B must be at least 1");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim_sel;

   if (LIM_A == LIM_B) begin : g_one_limit
      assign lim_sel = CW'(LIM_A);
      logic unused_rev;
      assign unused_rev = rev_b;
   end else begin : g_two_limits
      assign lim_sel = rev_b ? CW'(LIM_B) : CW'(LIM_A);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear) begin
         cnt <= '0;
      end else if (active && (cnt < CW'(LIM_MAX))) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign expired = (cnt >= lim_sel);

   // R9
   wd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt == '0));

   // R5
   wd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !clear) |=> $stable(cnt));
endmodule

// File: rtl/lbt_compare.sv
module lbt_compare #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              tx_stb,
   input  logic [DATA_W-1:0] tx_word,
   input  logic              rx_stb,
   input  logic [DATA_W-1:0] rx_word,
   output logic              no_echo,
   output logic              mismatch
);
   if (DATA_W < 1) begin : g_bad_w
      $error("lbt_compare: DATA_W must be at least 1");
   end

   logic [DATA_W-1:0] last_tx;
   logic [DATA_W-1:0] last_rx;
   logic [DATA_W-1:0] diff;
   logic              seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_tx <= '0;
         last_rx <= '0;
         seen    <= 1'b0;
      end else begin
         if (tx_stb) last_tx <= tx_word;
         if (rx_stb) last_rx <= rx_word;
         if (clear || tx_stb) seen <= 1'b0;
         else if (rx_stb)     seen <= 1'b1;
      end
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign diff[b] = last_tx[b] ^ last_rx[b];
   end

   assign no_echo  = !seen;
   assign mismatch = seen && (|diff);

   // R4
   echo_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_stb && !tx_stb && !clear) |=> !no_echo);

   // R3
   cmp_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_stb && !tx_stb && !clear && (rx_word == last_tx)) |=> !mismatch);
endmodule

// File: rtl/lbt_report.sv
module lbt_report
   import lbt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              rx_stb,
   input  logic [FLAG_N-1:0] rx_flags,
   input  logic              no_echo,
   input  logic              mismatch,
   input  logic              expired,
   input  logic              msg_end,
   input  logic              irq_en,
   output logic              status_fail,
   output logic              status_done,
   output logic              irq
);
   logic        flag_err;
   fail_cause_t cause;
   logic        fail_now;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_err <= 1'b0;
      end else if (clear) begin
         flag_err <= 1'b0;
      end else if (rx_stb && (|rx_flags)) begin
         flag_err <= 1'b1;
      end
   end

   assign cause = '{flag_err: flag_err, no_echo: no_echo,
                    mismatch: mismatch, timeout: expired};
   assign fail_now = |cause;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_fail <= 1'b0;
         status_done <= 1'b0;
         irq         <= 1'b0;
      end else begin
         status_done <= msg_end;
         irq         <= msg_end && fail_now && irq_en;
         if (msg_end) status_fail <= fail_now;
      end
   end

   // R2
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_stb && (|rx_flags) && !clear) |=> flag_err);

   // R7
   done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_end |=> status_done);

   // R7
   fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !status_done |-> $stable(status_fail));

   // R8
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (status_done && status_fail));
endmodule

// File: rtl/loopback_selftest.sv
module loopback_selftest #(
   parameter int DATA_W = 16,
   parameter int LIM_A  = 24,
   parameter int LIM_B  = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              msg_start,
   input  logic              msg_end,
   input  logic              rev_b,
   input  logic              irq_en,
   input  logic              tx_active,
   input  logic              tx_strobe,
   input  logic [DATA_W-1:0] tx_word,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_word,
   input  logic              rx_sync_err,
   input  logic              rx_enc_err,
   input  logic              rx_cnt_err,
   input  logic              rx_par_err,
   output logic              status_fail,
   output logic              status_done,
   output logic              irq
);
   import lbt_pkg::*;

   logic              no_echo;
   logic              mismatch;
   logic              expired;
   logic [FLAG_N-1:0] flags;

   assign flags = {rx_par_err, rx_cnt_err, rx_enc_err, rx_sync_err};

   lbt_watchdog #(.LIM_A(LIM_A), .LIM_B(LIM_B)) u_wd (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (msg_start),
      .active  (tx_active),
      .rev_b   (rev_b),
      .expired (expired)
   );

   lbt_compare #(.DATA_W(DATA_W)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (msg_start),
      .tx_stb   (tx_strobe),
      .tx_word  (tx_word),
      .rx_stb   (rx_valid),
      .rx_word  (rx_word),
      .no_echo  (no_echo),
      .mismatch (mismatch)
   );

   lbt_report u_rep (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (msg_start),
      .rx_stb      (rx_valid),
      .rx_flags    (flags),
      .no_echo     (no_echo),
      .mismatch    (mismatch),
      .expired     (expired),
      .msg_end     (msg_end),
      .irq_en      (irq_en),
      .status_fail (status_fail),
      .status_done (status_done),
      .irq         (irq)
   );

   // R8
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !msg_end) |=> !irq);

   // R9
   start_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_start |=> !mismatch);
endmodule

// File: tb/loopback_selftest_tb.sv
module loopback_selftest_tb;
   localparam int LA = 24;
   localparam int LB = 48;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        msg_start = 0, msg_end = 0, rev_b = 0, irq_en = 0;
   logic        tx_active = 0, tx_strobe = 0, rx_valid = 0;
   logic [15:0] tx_word = '0, rx_word = '0;
   logic        rx_sync_err = 0, rx_enc_err = 0, rx_cnt_err = 0, rx_par_err = 0;
   logic        status_fail, status_done, irq;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   loopback_selftest u_dut (
      .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .msg_end(msg_end),
      .rev_b(rev_b), .irq_en(irq_en), .tx_active(tx_active),
      .tx_strobe(tx_strobe), .tx_word(tx_word), .rx_valid(rx_valid),
      .rx_word(rx_word), .rx_sync_err(rx_sync_err), .rx_enc_err(rx_enc_err),
      .rx_cnt_err(rx_cnt_err), .rx_par_err(rx_par_err),
      .status_fail(status_fail), .status_done(status_done), .irq(irq)
   );

   task automatic check(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   function automatic bit exp_fail(int nw, int extra, bit rb, int flag_w,
                                   int mism_w, int drop_w);
      int lim = rb ? LB : LA;
      bit f = 0;
      if (flag_w >= 0 && flag_w < nw && flag_w != drop_w) f = 1;
      if (nw == 0 || drop_w == nw - 1) f = 1;
      if (mism_w == nw - 1 && drop_w != nw - 1) f = 1;
      if (nw + extra >= lim) f = 1;
      return f;
   endfunction

   // flag_k: 0 sync, 1 encoding, 2 bit count, 3 parity
   task automatic run_msg(string req, int nw, int extra, bit rb, bit ien,
                          int flag_w, int flag_k, int mism_w, int drop_w);
      bit ef = exp_fail(nw, extra, rb, flag_w, mism_w, drop_w);
      logic prev;
      @(negedge clk);
      msg_start = 1; rev_b = rb; irq_en = ien;
      @(negedge clk);
      msg_start = 0;
      for (int i = 0; i < nw; i++) begin
         logic [15:0] w = 16'($urandom);
         tx_strobe = 1; tx_active = 1; tx_word = w;
         @(negedge clk);
         tx_strobe = 0; tx_active = 0;
         rx_valid = (i != drop_w);
         rx_word  = (i == mism_w) ? (w ^ (16'h1 << ($urandom % 16))) : w;
         if (i == flag_w) begin
            rx_sync_err = (flag_k == 0); rx_enc_err = (flag_k == 1);
            rx_cnt_err  = (flag_k == 2); rx_par_err = (flag_k == 3);
         end
         @(negedge clk);
         rx_valid = 0;
         rx_sync_err = 0; rx_enc_err = 0; rx_cnt_err = 0; rx_par_err = 0;
      end
      for (int i = 0; i < extra; i++) begin
         tx_active = 1;
         @(negedge clk);
      end
      tx_active = 0;
      msg_end = 1;
      @(negedge clk);
      msg_end = 0;
      check({req, " R7 done"}, status_done, 1'b1);
      check({req, " fail"}, status_fail, ef);
      check({req, " R8 irq"}, irq, ef & ien);
      prev = status_fail;
      @(negedge clk);
      check("R7 done single", status_done, 1'b0);
      check("R8 irq single", irq, 1'b0);
      check("R7 hold", status_fail, prev);
   endtask

   initial begin
      void'($urandom(32'd1553));
      repeat (3) @(negedge clk);
      check("R1 fail", status_fail, 1'b0);
      check("R1 done", status_done, 1'b0);
      check("R1 irq", irq, 1'b0);
      rst_n = 1;
      @(negedge clk);
      run_msg("R6 clean A", 4, 5, 0, 1, -1, 0, -1, -1);
      run_msg("R2 sync", 3, 0, 0, 1, 1, 0, -1, -1);
      run_msg("R9 after fail", 3, 0, 0, 1, -1, 0, -1, -1);
      run_msg("R2 enc", 2, 0, 0, 1, 0, 1, -1, -1);
      run_msg("R2 cnt", 5, 0, 1, 1, 4, 2, -1, -1);
      run_msg("R2 par", 1, 0, 0, 1, 0, 3, -1, -1);
      run_msg("R3 last mismatch", 4, 0, 0, 1, -1, 0, 3, -1);
      run_msg("R3 early mismatch", 4, 0, 0, 1, -1, 0, 1, -1);
      run_msg("R4 drop last", 3, 0, 0, 1, -1, 0, -1, 2);
      run_msg("R4 drop early", 3, 0, 0, 1, -1, 0, -1, 0);
      run_msg("R4 no words", 0, 2, 0, 1, -1, 0, -1, -1);
      run_msg("R5 A limit-1", 3, LA - 4, 0, 1, -1, 0, -1, -1);
      run_msg("R5 A limit", 3, LA - 3, 0, 1, -1, 0, -1, -1);
      run_msg("R5 B over A", 3, LA + 4, 1, 1, -1, 0, -1, -1);
      run_msg("R5 B limit-1", 2, LB - 3, 1, 1, -1, 0, -1, -1);
      run_msg("R5 B limit", 2, LB - 2, 1, 1, -1, 0, -1, -1);
      run_msg("R8 irq off", 2, 0, 0, 0, 0, 3, -1, -1);
      run_msg("R6 clean B", 6, 10, 1, 0, -1, 0, -1, -1);
      for (int n = 0; n < 60; n++) begin
         int nw = 1 + ($urandom % 8);
         int ex = $urandom % 50;
         int fw = ($urandom % 4 == 0) ? int'($urandom % nw) : -1;
         int mw = ($urandom % 4 == 0) ? int'($urandom % nw) : -1;
         int dw = ($urandom % 5 == 0) ? int'($urandom % nw) : -1;
         run_msg("R2/R3/R4/R5/R6 random", nw, ex, 1'($urandom), 1'($urandom),
                 fw, int'($urandom % 4), mw, dw);
      end
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule